// File: doc/BRIEF.md
# JTAG TAP Shift Master

This block acts as the host side of a JTAG test access port. It drives the test clock, the mode-select line and the serial data line toward a target, and it samples the target's serial output. A single command starts one of four operations: a reset walk that leaves the target's TAP in Run-Test/Idle, a move from Run-Test/Idle into Shift-DR, a move from Run-Test/Idle into Shift-IR, or a serial transfer of 1 to 32 bits. While the transfer shifts the word out, it collects the bits coming back. When the operation ends, the block pulses `done` for one cycle, and `rdata` holds the captured word.

Each transfer sets its own options. It can send the least significant bit first or the most significant bit first. It can keep the target in the shift state so that a later transfer continues the same scan, or it can leave the shift state on the last bit. After leaving, it can also pass through Update and back to Run-Test/Idle, so that an update of a data register can clock the target's core. Instruction loads are 4-bit transfers sent LSB first, issued after the Shift-IR move. The test clock runs at a programmable fraction of the system clock.

The controller is a step engine with six states, and each test-clock cycle is one step:
- ST_IDLE: waits for a start. It moves to ST_RESET, ST_PATH or ST_SHIFT according to `cmd_op`.
- ST_RESET: holds TMS high for RESET_HI steps, then gives one step with TMS low. It then moves to ST_DONE.
- ST_PATH: plays a short TMS pattern. For a data register the pattern is 1,0,0. For the instruction register it is 1,1,0,0. It then moves to ST_DONE.
- ST_SHIFT: moves one data bit per step. After the last bit it moves to ST_POST when both the exit flag and the idle flag are set. Otherwise it moves to ST_DONE.
- ST_POST: two steps with TMS 1 (into Update) and then TMS 0 (into Run-Test/Idle). It then moves to ST_DONE.
- ST_DONE: pulses `done` for one cycle, then moves to ST_IDLE.

Top module: `jtag_shift_master`

## Requirements
- R1: A reset operation (`cmd_op`=1) gives at least five TCK cycles with TMS high, then one TCK cycle with TMS low. This leaves the target's TAP in Run-Test/Idle from any starting state.
- R2: A data-path move (`cmd_op`=2), started with the TAP in Run-Test/Idle, plays TMS 1,0,0, one bit per TCK cycle, and ends in Shift-DR.
- R3: An instruction-path move (`cmd_op`=3) plays TMS 1,1,0,0 and ends in Shift-IR. A following 4-bit, LSB-first transfer loads the instruction register.
- R4: In a transfer (`cmd_op`=0) with `cmd_lsb_first`=1, bit i of `cmd_data` is sent on TDI in step i. The TDO bit sampled in step i is placed in bit i of `rdata`.
- R5: In a transfer with `cmd_lsb_first`=0 and length n, bit n-1-i of `cmd_data` is sent in step i. The TDO bit of step i is placed in bit n-1-i of `rdata`.
- R6: The length is taken from `cmd_len`, from 1 to 32. A value of 0 or above 32 means 32. Data bits at or above the length are never sent. `rdata` bits at or above the length read 0.
- R7: With `cmd_exit`=0, TMS stays low on every bit. The TAP remains in the shift state, and a later transfer continues the same scan.
- R8: With `cmd_exit`=1, TMS is high on the last bit, so the TAP moves to Exit1. When `cmd_to_idle` is also 1, two more TCK cycles (TMS 1, then 0) pass through Update into Run-Test/Idle. When `cmd_exit`=0, `cmd_to_idle` has no effect.
- R9: TMS and TDI change only while TCK is low. TDO is sampled as TCK rises.
- R10: TCK stays high for `half_div` system clocks and low for `half_div` system clocks, with values below 2 treated as 2. TCK is low while the block is idle.
- R11: After reset, `busy`, `done` and `tck` are low. `busy` stays high from an accepted start until the cycle of the one-cycle `done` pulse. A start request while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| half_div | input | DIV_W | TCK half period in system clocks, sampled at start |
| cmd_start | input | 1 | Start request, accepted only when idle |
| cmd_op | input | 2 | 0 transfer, 1 TAP reset, 2 move to Shift-DR, 3 move to Shift-IR |
| cmd_data | input | DATA_W | Word to send |
| cmd_len | input | LEN_W | Bit count, 1 to DATA_W |
| cmd_lsb_first | input | 1 | 1 sends LSB first, 0 sends MSB first |
| cmd_exit | input | 1 | Leave the shift state on the last bit |
| cmd_to_idle | input | 1 | After an exit, pass through Update to Run-Test/Idle |
| tck | output | 1 | Test clock |
| tms | output | 1 | Test mode select |
| tdi | output | 1 | Serial data to the target |
| tdo | input | 1 | Serial data from the target |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| rdata | output | DATA_W | Captured word, valid at `done` and held until the next start |

## Verification
The bench attaches a behavioural model of the target's TAP state machine with a 64-bit shift chain. It checks the TAP state after every operation, the TDI bits that landed in the chain, and the captured word against the chain contents the bench predicted. The transfers cover both bit orders, lengths 1, 4, 8, 12 and 32, and a length of 0. A word with set bits above the length shows that those bits are dropped. Running two transfers back to back without exit tells a continued scan apart from a re-entered one. The exit-only case (ends in Exit1), the exit-plus-idle case (Update count rises, ends in Run-Test/Idle) and the idle-without-exit case (stays in Shift) are told apart by the final TAP state. A start pulse during a path move, carrying the reset operation, shows that it was dropped: the move still ends in Shift-DR and only one `done` pulse appears.

// File: rtl/jsm_pkg.sv
package jsm_pkg;

    typedef enum logic [1:0] {
        OP_SHIFT = 2'd0,
        OP_RESET = 2'd1,
        OP_TO_DR = 2'd2,
        OP_TO_IR = 2'd3
    } jsm_op_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RESET,
        ST_PATH,
        ST_SHIFT,
        ST_POST,
        ST_DONE
    } jsm_state_e;

endpackage

// File: rtl/jsm_tck_div.sv
module jsm_tck_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    output logic             tck,
    output logic             rise,
    output logic             fall
);
    localparam logic [DIV_W-1:0] MIN_HALF = DIV_W'(2);

    logic [DIV_W-1:0] half_q;
    logic [DIV_W-1:0] cnt;
    logic             edge_w;
    logic [DIV_W-1:0] half_eff;

    assign half_eff = (half_div < MIN_HALF) ? MIN_HALF : half_div;
    assign edge_w   = run && (cnt == '0);
    assign rise     = edge_w && !tck;
    assign fall     = edge_w && tck;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= MIN_HALF;
            cnt    <= '0;
            tck    <= 1'b0;
        end else if (load) begin
            half_q <= half_eff;
            cnt    <= half_eff - DIV_W'(1);
            tck    <= 1'b0;
        end else if (edge_w) begin
            cnt <= half_q - DIV_W'(1);
            tck <= ~tck;
        end else if (run) begin
            cnt <= cnt - DIV_W'(1);
        end
    end

    // R10: every TCK level lasts at least two system clocks
    a_r10_min_half: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tck) || $fell(tck)) |=> $stable(tck));

endmodule

// File: rtl/jsm_shifter.sv
module jsm_shifter #(
    parameter int DATA_W = 32,
    parameter int LEN_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [DATA_W-1:0] data,
    input  logic [LEN_W-1:0]  len,
    input  logic              lsb_first,
    input  logic              cap_en,
    input  logic              adv_en,
    input  logic              tdo,
    output logic              tdi,
    output logic [DATA_W-1:0] result
);
    logic [DATA_W-1:0] sreg;
    logic [DATA_W-1:0] cap;
    logic [LEN_W-1:0]  len_q;
    logic              lsb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg  <= '0;
            cap   <= '0;
            len_q <= LEN_W'(DATA_W);
            lsb_q <= 1'b1;
        end else if (load) begin
            // MSB-first words are left-aligned so the next bit is always the top bit
            sreg  <= lsb_first ? data : (data << (DATA_W - int'(len)));
            cap   <= '0;
            len_q <= len;
            lsb_q <= lsb_first;
        end else begin
            if (adv_en)
                sreg <= lsb_q ? (sreg >> 1) : (sreg << 1);
            if (cap_en)
                cap <= lsb_q ? {tdo, cap[DATA_W-1:1]} : {cap[DATA_W-2:0], tdo};
        end
    end

    assign tdi    = lsb_q ? sreg[0] : sreg[DATA_W-1];
    assign result = lsb_q ? (cap >> (DATA_W - int'(len_q))) : cap;

endmodule

// File: rtl/jtag_shift_master.sv
module jtag_shift_master
    import jsm_pkg::*;
#(
    parameter int DATA_W   = 32,
    parameter int DIV_W    = 8,
    parameter int RESET_HI = 5,
    parameter int LEN_W    = $clog2(DATA_W + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DIV_W-1:0]  half_div,
    input  logic              cmd_start,
    input  logic [1:0]        cmd_op,
    input  logic [DATA_W-1:0] cmd_data,
    input  logic [LEN_W-1:0]  cmd_len,
    input  logic              cmd_lsb_first,
    input  logic              cmd_exit,
    input  logic              cmd_to_idle,
    output logic              tck,
    output logic              tms,
    output logic              tdi,
    input  logic              tdo,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = LEN_W;
    localparam logic [LEN_W-1:0] FULL_LEN = LEN_W'(DATA_W);

    jsm_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] last_idx;
    logic [LEN_W-1:0] len_q;
    logic [LEN_W-1:0] len_eff;
    logic             exit_q;
    logic             idle_q;
    logic [3:0]       pat_q;
    logic [1:0]       plast_q;
    logic             start_ok;
    logic             is_last;
    logic             run;
    logic             rise;
    logic             fall;
    logic             sh_tdi;

    assign start_ok = cmd_start && (state == ST_IDLE);
    assign len_eff  = ((cmd_len == '0) || (cmd_len > FULL_LEN)) ? FULL_LEN : cmd_len;
    assign run      = (state != ST_IDLE) && (state != ST_DONE);
    assign is_last  = (idx == last_idx);

    always_comb begin
        unique case (state)
            ST_RESET: last_idx = IDX_W'(RESET_HI);
            ST_PATH:  last_idx = IDX_W'(plast_q);
            ST_SHIFT: last_idx = IDX_W'(len_q - LEN_W'(1));
            ST_POST:  last_idx = IDX_W'(1);
            default:  last_idx = '0;
        endcase
    end

    jsm_tck_div #(.DIV_W(DIV_W)) div_i (
        .clk(clk), .rst_n(rst_n), .load(start_ok), .run(run),
        .half_div(half_div), .tck(tck), .rise(rise), .fall(fall)
    );

    jsm_shifter #(.DATA_W(DATA_W), .LEN_W(LEN_W)) shf_i (
        .clk(clk), .rst_n(rst_n), .load(start_ok && (cmd_op == OP_SHIFT)),
        .data(cmd_data), .len(len_eff), .lsb_first(cmd_lsb_first),
        .cap_en(rise && (state == ST_SHIFT)), .adv_en(fall && (state == ST_SHIFT)),
        .tdo(tdo), .tdi(sh_tdi), .result(rdata)
    );

    // State register: steps advance on the falling TCK edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            idx     <= '0;
            len_q   <= FULL_LEN;
            exit_q  <= 1'b0;
            idle_q  <= 1'b0;
            pat_q   <= '0;
            plast_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start_ok) begin
                        idx    <= '0;
                        len_q  <= len_eff;
                        exit_q <= cmd_exit;
                        idle_q <= cmd_to_idle;
                        unique case (jsm_op_e'(cmd_op))
                            OP_SHIFT: state <= ST_SHIFT;
                            OP_RESET: state <= ST_RESET;
                            OP_TO_DR: begin
                                state   <= ST_PATH;
                                pat_q   <= 4'b0001;
                                plast_q <= 2'd2;
                            end
                            OP_TO_IR: begin
                                state   <= ST_PATH;
                                pat_q   <= 4'b0011;
                                plast_q <= 2'd3;
                            end
                            default: state <= ST_IDLE;
                        endcase
                    end
                end
                ST_RESET, ST_PATH, ST_SHIFT, ST_POST: begin
                    if (fall) begin
                        if (is_last) begin
                            idx   <= '0;
                            state <= ((state == ST_SHIFT) && exit_q && idle_q) ? ST_POST : ST_DONE;
                        end else begin
                            idx <= idx + IDX_W'(1);
                        end
                    end
                end
                ST_DONE: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        tms  = 1'b0;
        tdi  = 1'b0;
        busy = (state != ST_IDLE);
        done = (state == ST_DONE);
        unique case (state)
            ST_RESET: tms = (idx < IDX_W'(RESET_HI));
            ST_PATH:  tms = pat_q[idx[1:0]];
            ST_SHIFT: begin
                tms = exit_q && is_last;
                tdi = sh_tdi;
            end
            ST_POST:  tms = (idx == '0);
            default:  tms = 1'b0;
        endcase
    end

    // R9: mode and data lines hold while TCK is high
    a_r9_tms_held: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> $stable(tms));
    a_r9_tdi_held: assert property (@(posedge clk) disable iff (!rst_n)
        tck |-> $stable(tdi));
    // R11: done is a single-cycle pulse inside busy, and busy ends only there
    a_r11_done_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> busy);
    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r11_busy_end: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> $past(done));

endmodule

// File: tb/jtag_shift_master_tb_top.sv
module jtag_shift_master_tb_top;
    localparam int CLK_P  = 10;
    localparam int DATA_W = 32;
    localparam int DIV_W  = 8;
    localparam int LEN_W  = 6;

    typedef enum logic [3:0] {
        T_TLR, T_RTI, T_SELDR, T_CAPDR, T_SDR, T_EX1DR, T_PDR, T_EX2DR, T_UDR,
        T_SELIR, T_CAPIR, T_SIR, T_EX1IR, T_PIR, T_EX2IR, T_UIR
    } tap_e;

    typedef struct {
        bit          chk;
        logic [31:0] val;
        string       tag;
    } exp_t;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [DIV_W-1:0]  half_div = 8'd3;
    logic              cmd_start = 1'b0;
    logic [1:0]        cmd_op = 2'd0;
    logic [DATA_W-1:0] cmd_data = '0;
    logic [LEN_W-1:0]  cmd_len = '0;
    logic              cmd_lsb_first = 1'b0;
    logic              cmd_exit = 1'b0;
    logic              cmd_to_idle = 1'b0;
    logic              tck, tms, tdi, tdo, busy, done;
    logic [DATA_W-1:0] rdata;

    int total = 0;
    int bad = 0;
    int done_cnt = 0;
    int upd_cnt = 0;
    int streak = 0;
    int last_streak = 0;
    int hi_run = 0;
    int last_hi = 0;
    int edge_viol = 0;
    logic  tms_prev = 1'b0, tdi_prev = 1'b0;
    tap_e  tap = T_SDR;
    logic [63:0] tgt_sr = 64'h0123_4567_89AB_CDEF;
    exp_t  exp_q[$];

    always #(CLK_P/2) clk = ~clk;

    jtag_shift_master #(.DATA_W(DATA_W), .DIV_W(DIV_W)) dut_i (
        .clk(clk), .rst_n(rst_n), .half_div(half_div), .cmd_start(cmd_start),
        .cmd_op(cmd_op), .cmd_data(cmd_data), .cmd_len(cmd_len),
        .cmd_lsb_first(cmd_lsb_first), .cmd_exit(cmd_exit), .cmd_to_idle(cmd_to_idle),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo), .busy(busy), .done(done),
        .rdata(rdata)
    );

    function automatic tap_e tap_next(tap_e s, logic m);
        case (s)
            T_TLR:   return m ? T_TLR   : T_RTI;
            T_RTI:   return m ? T_SELDR : T_RTI;
            T_SELDR: return m ? T_SELIR : T_CAPDR;
            T_CAPDR: return m ? T_EX1DR : T_SDR;
            T_SDR:   return m ? T_EX1DR : T_SDR;
            T_EX1DR: return m ? T_UDR   : T_PDR;
            T_PDR:   return m ? T_EX2DR : T_PDR;
            T_EX2DR: return m ? T_UDR   : T_SDR;
            T_UDR:   return m ? T_SELDR : T_RTI;
            T_SELIR: return m ? T_TLR   : T_CAPIR;
            T_CAPIR: return m ? T_EX1IR : T_SIR;
            T_SIR:   return m ? T_EX1IR : T_SIR;
            T_EX1IR: return m ? T_UIR   : T_PIR;
            T_PIR:   return m ? T_EX2IR : T_PIR;
            T_EX2IR: return m ? T_UIR   : T_SIR;
            default: return m ? T_SELDR : T_RTI;
        endcase
    endfunction

    // Target model: TAP state machine with a 64-bit chain
    assign tdo = tgt_sr[0];
    always @(posedge tck) begin
        if (tap == T_SDR || tap == T_SIR)
            tgt_sr <= {tdi, tgt_sr[63:1]};
        if (tap_next(tap, tms) == T_UDR || tap_next(tap, tms) == T_UIR)
            upd_cnt <= upd_cnt + 1;
        if (tms) streak <= streak + 1;
        else begin
            last_streak <= streak;
            streak <= 0;
        end
        tap <= tap_next(tap, tms);
    end

    // Line monitor: TCK high time and TMS/TDI stability while TCK is high
    always @(negedge clk) begin
        if (tck) begin
            hi_run <= hi_run + 1;
            if (tms !== tms_prev || tdi !== tdi_prev) edge_viol <= edge_viol + 1;
        end else if (hi_run > 0) begin
            last_hi <= hi_run;
            hi_run <= 0;
        end
        tms_prev <= tms;
        tdi_prev <= tdi;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] expv);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (done) begin
            done_cnt <= done_cnt + 1;
            if (exp_q.size() == 0) begin
                check(1'b0, "R11 unexpected done", 64'(rdata), 64'h0);
            end else begin
                exp_t e;
                e = exp_q.pop_front();
                if (e.chk) check(rdata === e.val, e.tag, 64'(rdata), 64'(e.val));
            end
        end
    end

    task automatic run_cmd(input logic [1:0] op, input logic [31:0] d, input int n,
                           input bit lsb, input bit ex, input bit id, input string tag);
        exp_t e;
        int neff;
        logic [31:0] want_tdi;
        logic [31:0] got_tdi;
        neff = (n == 0 || n > 32) ? 32 : n;
        e.chk = (op == 2'd0);
        e.tag = tag;
        e.val = '0;
        want_tdi = '0;
        for (int i = 0; i < neff; i++) begin
            if (lsb) begin
                e.val[i] = tgt_sr[i];
                want_tdi[i] = d[i];
            end else begin
                e.val[neff-1-i] = tgt_sr[i];
                want_tdi[i] = d[neff-1-i];
            end
        end
        exp_q.push_back(e);
        @(negedge clk);
        cmd_op = op; cmd_data = d; cmd_len = LEN_W'(n);
        cmd_lsb_first = lsb; cmd_exit = ex; cmd_to_idle = id;
        cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (!done) @(negedge clk);
        @(negedge clk);
        if (op == 2'd0) begin
            got_tdi = '0;
            for (int i = 0; i < neff; i++) got_tdi[i] = tgt_sr[64-neff+i];
            check(got_tdi === want_tdi, {tag, " tdi bits"}, 64'(got_tdi), 64'(want_tdi));
        end
    endtask

    initial begin
        #(CLK_P * 150000);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int u0;
        int d0;
        repeat (5) @(negedge clk);
        check(busy === 1'b0 && done === 1'b0 && tck === 1'b0, "R11 reset state",
              {61'd0, busy, done, tck}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);

        run_cmd(2'd1, 0, 1, 1, 0, 0, "R1");
        check(tap == T_RTI, "R1 tap after reset", 64'(tap), 64'(T_RTI));
        check(last_streak >= 5, "R1 tms high run", 64'(last_streak), 64'd5);
        check(last_hi == 3, "R10 half period 3", 64'(last_hi), 64'd3);

        run_cmd(2'd2, 0, 1, 1, 0, 0, "R2");
        check(tap == T_SDR, "R2 tap in shift-dr", 64'(tap), 64'(T_SDR));

        run_cmd(2'd0, 32'h0000_00A5, 8, 1, 0, 0, "R4 lsb capture");
        check(tap == T_SDR, "R7 still in shift", 64'(tap), 64'(T_SDR));
        run_cmd(2'd0, 32'hFFFF_F3C9, 12, 0, 1, 0, "R5 msb capture");
        check(tap == T_EX1DR, "R8 exit only", 64'(tap), 64'(T_EX1DR));

        run_cmd(2'd1, 0, 1, 1, 0, 0, "R1 again");
        run_cmd(2'd2, 0, 1, 1, 0, 0, "R2 again");
        u0 = upd_cnt;
        run_cmd(2'd0, 32'hDEAD_BEEF, 32, 1, 1, 1, "R6 len 32");
        check(tap == T_RTI, "R8 exit to idle", 64'(tap), 64'(T_RTI));
        check(upd_cnt == u0 + 1, "R8 update passed", 64'(upd_cnt), 64'(u0 + 1));

        run_cmd(2'd2, 0, 1, 1, 0, 0, "R2 len1");
        run_cmd(2'd0, 32'hFFFF_FFFF, 1, 0, 1, 1, "R6 len 1");

        run_cmd(2'd3, 0, 1, 1, 0, 0, "R3");
        check(tap == T_SIR, "R3 tap in shift-ir", 64'(tap), 64'(T_SIR));
        run_cmd(2'd0, 32'h0000_000B, 4, 1, 1, 1, "R3 ir load");
        check(tap == T_RTI, "R3 back to idle", 64'(tap), 64'(T_RTI));

        run_cmd(2'd2, 0, 1, 1, 0, 0, "R2 len0");
        run_cmd(2'd0, 32'h1357_9BDF, 0, 0, 0, 1, "R6 len 0 as 32");
        check(tap == T_SDR, "R8 idle ignored without exit", 64'(tap), 64'(T_SDR));

        half_div = 8'd0;
        run_cmd(2'd1, 0, 1, 1, 0, 0, "R10 fast reset");
        check(last_hi == 2, "R10 half period floor", 64'(last_hi), 64'd2);
        check(tap == T_RTI, "R1 fast reset", 64'(tap), 64'(T_RTI));

        // R11: start during a path move is dropped
        d0 = done_cnt;
        exp_q.push_back('{chk: 1'b0, val: 32'h0, tag: "R11"});
        @(negedge clk);
        cmd_op = 2'd2; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        repeat (6) @(negedge clk);
        check(busy === 1'b1, "R11 busy mid op", 64'(busy), 64'd1);
        cmd_op = 2'd1; cmd_start = 1'b1;
        @(negedge clk);
        cmd_start = 1'b0;
        while (!done) @(negedge clk);
        repeat (40) @(negedge clk);
        check(tap == T_SDR, "R11 ignored start", 64'(tap), 64'(T_SDR));
        check(done_cnt == d0 + 1, "R11 single done", 64'(done_cnt), 64'(d0 + 1));
        check(busy === 1'b0, "R11 busy cleared", 64'(busy), 64'd0);

        check(edge_viol == 0, "R9 lines held while tck high", 64'(edge_viol), 64'd0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule